// File: doc/BRIEF.md
# LCD Row/Column Scan Timing Generator

This block refreshes a passive dot-matrix panel of 120 columns by 64 rows at 1/64 duty. A divider turns the system clock into line periods. At the start of each line the block advances a one-hot row token through two cascaded 32-stage row shift registers. It also latches the 120 memory bits that belong to that row into the column outputs, and holds them for the whole line. A frame sync marks the line of the first row. An AC-inversion level flips at every frame start, so the drive polarity alternates from frame to frame.

Two identical chips can share one scan. In expansion mode the master keeps its own divider and drives the line clock, frame sync and AC level out. The slave takes those same signals as inputs, restarts its row count whenever the frame sync is seen at a line start, and lights only the upper row half. The master lights only the lower half. Standby blanks every row and column output while the scan keeps running, so the picture returns in step when standby ends.

The display memory sits outside the block and is read asynchronously. The block presents the index of the row that the next line start will select, and samples the returned 120-bit word at that line start.

Top module: `lcd_scan_gen`

## Requirements
- R1: While `rst_n` is low, `row_sel`, `col_out`, `line_o`, `frame_o`, `ac_o` and `drive_pol` are all zero, and `mem_addr` is 0.
- R2: In single or master role, a line lasts exactly 4·2^`fsel` clock cycles. `line_o` is high for exactly one cycle at the start of each line, and the first line starts 4·2^`fsel` cycles after reset is released.
- R3: Rows are selected one at a time, in the order 1 to 64 and then back to 1. Bit i of `row_sel` is row i+1. `frame_o` is high for the whole line of row 1 and low for every other line.
- R4: At each line start, `col_out` takes the memory word present on `mem_data` and holds it until the next line start. `mem_addr` is the 0-based index of the row that the next line start will select.
- R5: `ac_o` and `drive_pol` toggle at the start of every frame, at the same time that row 1 is selected, and are high during the first frame after reset.
- R6: With `expand_en` low, all 64 row bits can be active, and the chip drives the sync outputs with `sync_oe` high.
- R7: With `expand_en` high and `master_sel` high, `row_sel[63:32]` is always zero, rows 1 to 32 scan normally, and the sync outputs are driven with `sync_oe` high.
- R8: With `expand_en` high and `master_sel` low, `row_sel[31:0]` is always zero, and `sync_oe`, `line_o`, `frame_o` and `ac_o` are zero. A line starts on the clock after `line_i` is high. If `frame_i` is high at that point, the row restarts at row 1, even in mid-frame. `drive_pol` follows `ac_i` one cycle later.
- R9: While `stby_n` is low, `row_sel` and `col_out` are zero. The scan keeps its place, so outputs match the unblanked scan as soon as `stby_n` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stby_n | input | 1 | Standby when low: blanks rows and columns |
| expand_en | input | 1 | Two-chip expansion enable |
| master_sel | input | 1 | Role in expansion: 1 master, 0 slave |
| fsel | input | 2 | Line period select, 4·2^fsel cycles |
| line_i | input | 1 | Line clock from master (slave role) |
| frame_i | input | 1 | Frame sync from master (slave role) |
| ac_i | input | 1 | AC-inversion level from master (slave role) |
| line_o | output | 1 | Line clock pulse (master/single role) |
| frame_o | output | 1 | Frame sync (master/single role) |
| ac_o | output | 1 | AC-inversion level (master/single role) |
| sync_oe | output | 1 | High when the sync outputs are to be driven |
| drive_pol | output | 1 | Drive polarity used by this chip |
| mem_addr | output | 6 | Row index for the display memory read |
| mem_data | input | 120 | Column bits of the addressed row |
| row_sel | output | 64 | Row select, bit i is row i+1 |
| col_out | output | 120 | Latched column data for the current line |

## Verification
The frame boundary is the cycle where the most things happen at once. The row token is reinjected at stage one while the old token falls off stage 64, the column latch takes the word of row 1, `mem_addr` wraps, the frame sync rises and the AC level flips. Runs of two or more frames at several line periods make this cycle recur, and a bench model judges it by computing row, polarity and data from the number of clocks since reset. In slave role the bench also raises the frame sync in mid-frame. The restart then meets the normal token shift in the same line start, and the bench expects a single token at row 1 with the row-1 memory word.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  // Chip role, decided from the expansion and role pins.
  typedef enum logic [1:0] {
    ROLE_SINGLE = 2'd0,
    ROLE_MASTER = 2'd1,
    ROLE_SLAVE  = 2'd2
  } role_e;

endpackage

// File: rtl/lcd_scan_div.sv
module lcd_scan_div #(
  parameter int BASE_DIV = 4,
  parameter int FSW      = 2,
  parameter int CW       = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic [FSW-1:0] fsel,
  output logic           tick
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] last;

  // Terminal count; compare with >= so a live fsel change cannot overrun.
  assign last = CW'((BASE_DIV << fsel) - 1);
  assign tick = run && (cnt_q >= last);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: line starts are never back to back.
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/lcd_row_shifter.sv
module lcd_row_shifter #(
  parameter int BANK  = 32,
  parameter int NBANK = 2,
  localparam int NROW = BANK * NBANK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             inject,
  input  logic             stby_n,
  input  logic [NBANK-1:0] bank_en,
  output logic [NROW-1:0]  row_sel
);

  logic [NROW-1:0] chain;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [BANK-1:0] sr_q, sr_d;
    logic            feed;

    if (b == 0) begin : g_head
      assign feed = inject;
    end else begin : g_link
      assign feed = chain[b*BANK-1] & ~inject;
    end

    always_comb begin
      sr_d = sr_q;
      if (tick) begin
        if (inject) sr_d = (b == 0) ? BANK'(1) : '0;
        else        sr_d = {sr_q[BANK-2:0], feed};
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= '0;
      else        sr_q <= sr_d;
    end

    assign chain[b*BANK +: BANK]   = sr_q;
    assign row_sel[b*BANK +: BANK] = (stby_n && bank_en[b]) ? sr_q : '0;
  end

  // R3: never more than one row token in the chain.
  p_token_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chain));

  // R3: the token only moves at a line start.
  p_token_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(chain));

  // R3: an injection leaves exactly the first stage set.
  p_inject_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && inject) |=> (chain == NROW'(1)));

endmodule

// File: rtl/lcd_col_latch.sv
module lcd_col_latch #(
  parameter int NCOL = 120
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            stby_n,
  input  logic [NCOL-1:0] mem_data,
  output logic [NCOL-1:0] col_out
);

  logic [NCOL-1:0] col_q, col_d;

  always_comb begin
    col_d = col_q;
    if (tick) col_d = mem_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) col_q <= '0;
    else        col_q <= col_d;
  end

  assign col_out = stby_n ? col_q : '0;

  // R4: a line start captures the memory word of that cycle.
  p_col_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (col_q == $past(mem_data)));

  // R4: column data is held for the rest of the line.
  p_col_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(col_q));

endmodule

// File: rtl/lcd_scan_gen.sv
module lcd_scan_gen
  import lcd_scan_pkg::*;
#(
  parameter int NCOL     = 120,
  parameter int BANK     = 32,
  parameter int NBANK    = 2,
  parameter int BASE_DIV = 4,
  parameter int FSW      = 2,
  localparam int NROW    = BANK * NBANK,
  localparam int RW      = $clog2(NROW),
  localparam int CW      = $clog2(BASE_DIV << ((1 << FSW) - 1))
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stby_n,
  input  logic            expand_en,
  input  logic            master_sel,
  input  logic [FSW-1:0]  fsel,
  input  logic            line_i,
  input  logic            frame_i,
  input  logic            ac_i,
  output logic            line_o,
  output logic            frame_o,
  output logic            ac_o,
  output logic            sync_oe,
  output logic            drive_pol,
  output logic [RW-1:0]   mem_addr,
  input  logic [NCOL-1:0] mem_data,
  output logic [NROW-1:0] row_sel,
  output logic [NCOL-1:0] col_out
);

  role_e            role;
  logic             slave;
  logic [NBANK-1:0] bank_en;
  logic             div_tick, tick, inject;
  logic [RW-1:0]    row_q, row_d, next_row;
  logic             line_q, line_d;
  logic             frame_q, frame_d;
  logic             ac_q, ac_d;

  // Role decode and active row halves.
  always_comb begin
    if (!expand_en)     role = ROLE_SINGLE;
    else if (master_sel) role = ROLE_MASTER;
    else                role = ROLE_SLAVE;
  end
  assign slave = (role == ROLE_SLAVE);

  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      case (role)
        ROLE_MASTER: bank_en[b] = (b < NBANK / 2);
        ROLE_SLAVE:  bank_en[b] = (b >= NBANK / 2);
        default:     bank_en[b] = 1'b1;
      endcase
    end
  end

  lcd_scan_div #(.BASE_DIV(BASE_DIV), .FSW(FSW), .CW(CW)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (!slave),
    .fsel  (fsel),
    .tick  (div_tick)
  );

  // Line sequencing.
  assign tick = slave ? line_i : div_tick;

  always_comb begin
    if (slave && frame_i)            next_row = '0;
    else if (row_q == RW'(NROW - 1)) next_row = '0;
    else                             next_row = row_q + 1'b1;
  end

  assign inject   = tick && (next_row == '0);
  assign mem_addr = next_row;

  always_comb begin
    row_d   = tick ? next_row : row_q;
    line_d  = tick;
    frame_d = tick ? (next_row == '0) : frame_q;
    if (slave)       ac_d = ac_i;
    else if (inject) ac_d = ~ac_q;
    else             ac_d = ac_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q   <= RW'(NROW - 1);
      line_q  <= 1'b0;
      frame_q <= 1'b0;
      ac_q    <= 1'b0;
    end else begin
      row_q   <= row_d;
      line_q  <= line_d;
      frame_q <= frame_d;
      ac_q    <= ac_d;
    end
  end

  assign sync_oe   = !slave;
  assign line_o    = !slave && line_q;
  assign frame_o   = !slave && frame_q;
  assign ac_o      = !slave && ac_q;
  assign drive_pol = ac_q;

  lcd_row_shifter #(.BANK(BANK), .NBANK(NBANK)) u_rows (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .inject  (inject),
    .stby_n  (stby_n),
    .bank_en (bank_en),
    .row_sel (row_sel)
  );

  lcd_col_latch #(.NCOL(NCOL)) u_cols (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .stby_n   (stby_n),
    .mem_data (mem_data),
    .col_out  (col_out)
  );

  // R3: frame sync is high exactly while the first row is current.
  p_frame_row1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    line_q |-> (frame_q == (row_q == '0)));

  // R5: in a driving role the polarity only flips with a fresh frame sync.
  p_ac_at_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave && !$past(slave) && (ac_q != $past(ac_q))) |-> (frame_q && line_q));

  // R9: standby blanks all drive outputs.
  p_standby_dark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_n |-> ((row_sel == '0) && (col_out == '0)));

  // R7, R8: the inactive half stays dark in expansion mode.
  p_master_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (role == ROLE_MASTER) |-> (row_sel[NROW-1:NROW/2] == '0));
  p_slave_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (role == ROLE_SLAVE) |-> (row_sel[NROW/2-1:0] == '0));

endmodule

// File: tb/lcd_scan_gen_test.sv
`timescale 1ns/1ps
module lcd_scan_gen_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         stby_n = 1'b1;
  logic         expand_en = 1'b0;
  logic         master_sel = 1'b1;
  logic [1:0]   fsel = 2'd0;
  logic         line_i = 1'b0;
  logic         frame_i = 1'b0;
  logic         ac_i = 1'b0;
  logic         line_o, frame_o, ac_o, sync_oe, drive_pol;
  logic [5:0]   mem_addr;
  logic [119:0] mem_data;
  logic [63:0]  row_sel;
  logic [119:0] col_out;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;
  logic [31:0] salt;

  always #2.5 clk = ~clk;

  // Display memory model: a fixed pattern per row index.
  function automatic logic [119:0] mem_fn(input int r);
    logic [31:0] a;
    a = (32'(r) + 32'd1) * 32'h9E37_79B1 ^ salt;
    return {a[23:0], a ^ 32'h5A5A_5A5A, ~a, a * 32'd7};
  endfunction

  assign mem_data = mem_fn(int'(mem_addr));

  lcd_scan_gen uut (
    .clk(clk), .rst_n(rst_n), .stby_n(stby_n),
    .expand_en(expand_en), .master_sel(master_sel), .fsel(fsel),
    .line_i(line_i), .frame_i(frame_i), .ac_i(ac_i),
    .line_o(line_o), .frame_o(frame_o), .ac_o(ac_o),
    .sync_oe(sync_oe), .drive_pol(drive_pol),
    .mem_addr(mem_addr), .mem_data(mem_data),
    .row_sel(row_sel), .col_out(col_out)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] half_mask(input bit ex, input bit ms);
    if (!ex)     return '1;
    else if (ms) return {32'h0, 32'hFFFF_FFFF};
    else         return {32'hFFFF_FFFF, 32'h0};
  endfunction

  // Reset pulse with checks of the reset state (R1).
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    stby_n = 1'b1;
    #1;
    chk(row_sel == '0, "R1 row_sel", 128'(row_sel), 128'h0);
    chk(col_out == '0, "R1 col_out", 128'(col_out), 128'h0);
    chk({line_o, frame_o, ac_o, drive_pol} == 4'b0, "R1 sync",
        128'({line_o, frame_o, ac_o, drive_pol}), 128'h0);
    chk(mem_addr == 6'd0, "R1 mem_addr", 128'(mem_addr), 128'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Master or single role: expected values from clock count since reset.
  task automatic run_master(input int fs, input bit ex, input int cycles,
                            input bit rand_stby);
    int L;
    int e;
    L = 4 << fs;
    fsel = 2'(fs);
    expand_en = ex;
    master_sel = 1'b1;
    do_reset();
    chk(sync_oe == 1'b1, ex ? "R7 sync_oe" : "R6 sync_oe", 128'(sync_oe), 128'h1);
    e = 0;
    repeat (cycles) begin
      logic [63:0]  rs_e;
      logic [119:0] c_e;
      bit           ln_e, fr_e, ac_e;
      int           r;
      int           n;
      @(posedge clk);
      e++;
      @(negedge clk);
      if (e < L) begin
        rs_e = '0; c_e = '0; ln_e = 0; fr_e = 0; ac_e = 0; r = 63;
      end else begin
        n = e / L;
        r = (n - 1) % 64;
        ln_e = (e % L) == 0;
        fr_e = (r == 0);
        ac_e = (((n - 1) / 64) % 2) == 0;
        rs_e = (64'b1 << r) & half_mask(ex, 1'b1);
        c_e = mem_fn(r);
      end
      if (!stby_n) begin
        rs_e = '0;
        c_e = '0;
      end
      chk(line_o == ln_e, "R2 line_o", 128'(line_o), 128'(ln_e));
      chk(frame_o == fr_e, "R3 frame_o", 128'(frame_o), 128'(fr_e));
      chk(row_sel == rs_e, ex ? "R7 row_sel" : (stby_n ? "R3 R6 row_sel" : "R9 row_sel"),
          128'(row_sel), 128'(rs_e));
      chk(col_out == c_e, stby_n ? "R4 col_out" : "R9 col_out",
          128'(col_out), 128'(c_e));
      chk(mem_addr == 6'((r + 1) % 64), "R4 mem_addr", 128'(mem_addr),
          128'((r + 1) % 64));
      chk(ac_o == ac_e && drive_pol == ac_e, "R5 ac_o",
          128'({ac_o, drive_pol}), 128'({ac_e, ac_e}));
      if (rand_stby) stby_n = ($urandom % 4) != 0;
    end
    stby_n = 1'b1;
  endtask

  // Slave role: bench acts as the master, with a mid-frame restart.
  task automatic run_slave(input int lines, input int restart_at);
    bit acv;
    expand_en = 1'b1;
    master_sel = 1'b0;
    line_i = 1'b0;
    frame_i = 1'b0;
    ac_i = 1'b0;
    acv = 1'b0;
    do_reset();
    for (int i = 0; i < lines; i++) begin
      int r;
      int P;
      logic [63:0] rs_e;
      logic [5:0]  ma_e;
      P = 3 + int'($urandom % 4);
      r = (i < restart_at) ? (i % 64) : ((i - restart_at) % 64);
      @(negedge clk);
      line_i = 1'b1;
      frame_i = (r == 0);
      if (r == 0) acv = ~acv;
      ac_i = acv;
      @(posedge clk);
      @(negedge clk);
      line_i = 1'b0;
      rs_e = (r >= 32) ? (64'b1 << r) : 64'h0;
      ma_e = (r == 0) ? 6'd0 : 6'((r + 1) % 64);
      for (int k = 0; k < P; k++) begin
        if (k > 0) begin
          @(posedge clk);
          @(negedge clk);
        end
        chk(row_sel == rs_e, (i == restart_at) ? "R8 restart row_sel" : "R8 row_sel",
            128'(row_sel), 128'(rs_e));
        chk(col_out == mem_fn(r), "R4 R8 col_out", 128'(col_out), 128'(mem_fn(r)));
        chk(mem_addr == ma_e, "R8 mem_addr", 128'(mem_addr), 128'(ma_e));
        chk({sync_oe, line_o, frame_o, ac_o} == 4'b0, "R8 sync quiet",
            128'({sync_oe, line_o, frame_o, ac_o}), 128'h0);
        chk(drive_pol == acv, "R8 drive_pol", 128'(drive_pol), 128'(acv));
      end
    end
  endtask

  initial begin
    salt = $urandom(32'd20240611);
    salt = $urandom;
    run_master(0, 1'b0, 4 * 64 * 2 + 40, 1'b0);
    salt = $urandom;
    run_master(1, 1'b0, 700, 1'b0);
    salt = $urandom;
    run_master(3, 1'b0, 32 * 64 * 2 + 70, 1'b0);
    salt = $urandom;
    run_master(2, 1'b1, 16 * 64 * 2 + 50, 1'b1);
    salt = $urandom;
    run_master(0, 1'b0, 600, 1'b1);
    salt = $urandom;
    run_slave(80, 70);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule